// File: doc/BRIEF.md
# Protected Memory-Timing Register Bank

This block holds the bus timing configuration for a set of chip selects on an external static memory controller. Software reaches it through a single-request register port: one read or one write per cycle, addressed by word index. Every chip select owns a group of four words: a setup word with four strobe-setup codes, a pulse word with four strobe-width codes, a cycle word with a read and a write cycle-length code, and an 8-bit mode word. Two more words follow the groups: a guard word that holds the protection enable and a status word that logs blocked writes.

When the guard is on, writes to any chip-select word are refused. Each refused write raises a sticky violation flag and records the word index it aimed at. Reading the status word returns the flag and then clears it. The guard word can always be written, so protection can be turned off again.

The stored codes are compact. The bank expands every code into its effective cycle count on combinational outputs, one set per chip select, so the strobe generator downstream works with plain counts.

Top module: `tcfg_regfile`

## Requirements
- R1: After reset every register reads zero, protection is off, the violation flag is clear and all effective outputs are zero.
- R2: Chip select c owns word indices 4c (setup), 4c+1 (pulse), 4c+2 (cycle) and 4c+3 (mode). Setup codes are 6 bits at [5:0], [13:8], [21:16], [29:24], in the order read strobe, chip-select-on-read, write strobe, chip-select-on-write. Pulse codes are 7 bits at the same four byte lanes in the same order. The read cycle code sits at [8:0] and the write cycle code at [24:16]. The mode code sits at [7:0]. Unused bits read zero. Read data appears on `rd_data` in the cycle after the read request.
- R3: Word index 4·NUM_CS is the guard word, with the enable at bit 0. It is always writable, including while protection is on, and it reads back its bit.
- R4: While protection is on, a write to any chip-select word leaves that word unchanged.
- R5: A refused write sets the flag (status bit 0) from the next cycle. The flag stays set until the status word is read.
- R6: Status bits [15:8] hold the word index of the most recent refused write. A later refused write overwrites the index while the flag stays set.
- R7: A read of the status word (index 4·NUM_CS+1) returns the flag and index as they are, then clears the flag. The index is kept.
- R8: Writes to the status word or to indices above it change no register.
- R9: A setup code s is expanded to 128·s[5] + s[4:0] (0..159), eight bits per code on `eff_setup`, slot 4c+f for field f of chip select c.
- R10: A pulse code p is expanded to 256·p[6] + p[5:0] (0..319), nine bits per code on `eff_pulse`, slot 4c+f.
- R11: A cycle code y is expanded to 256·y[8:7] + y[6:0] (0..895), ten bits per code on `eff_cycle`, slot 2c for read and 2c+1 for write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Register request this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ADDR_W | Word index |
| req_wdata | input | 32 | Write data |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| eff_setup | output | NUM_CS·4·8 | Effective setup counts |
| eff_pulse | output | NUM_CS·4·9 | Effective pulse counts |
| eff_cycle | output | NUM_CS·2·10 | Effective cycle counts |

## Verification
Each request is driven on a falling edge and taken at the next rising edge. The bench waits one edge before it looks at any result. A read's data is registered at that edge, so the bench samples `rd_data` at the following falling edge. A write, allowed or refused, updates the stored word, the flag or the index at that same rising edge, so the effective outputs and any later read see the new state after one edge. A clear caused by a status read appears only from the next request onward. The bench therefore proves it with a second status read one cycle later.

// File: rtl/tcfg_pkg.sv
package tcfg_pkg;

    typedef struct packed {
        logic       flag;
        logic [7:0] src;
    } wp_st_t;

    function automatic logic [31:0] kind_mask(input logic [1:0] kind);
        case (kind)
            2'd0:    return 32'h3F3F_3F3F;
            2'd1:    return 32'h7F7F_7F7F;
            2'd2:    return 32'h01FF_01FF;
            default: return 32'h0000_00FF;
        endcase
    endfunction

    function automatic logic [7:0] expand_setup(input logic [5:0] c);
        return (c[5] ? 8'd128 : 8'd0) + {3'b0, c[4:0]};
    endfunction

    function automatic logic [8:0] expand_pulse(input logic [6:0] c);
        return (c[6] ? 9'd256 : 9'd0) + {3'b0, c[5:0]};
    endfunction

    function automatic logic [9:0] expand_cycle(input logic [8:0] c);
        return {c[8:7], 8'd0} + {3'b0, c[6:0]};
    endfunction

endpackage

// File: rtl/tcfg_decode.sv
module tcfg_decode
    import tcfg_pkg::*;
(
    input  logic [31:0]      setup_word,
    input  logic [31:0]      pulse_word,
    input  logic [31:0]      cycle_word,
    output logic [4*8-1:0]   eff_setup,
    output logic [4*9-1:0]   eff_pulse,
    output logic [2*10-1:0]  eff_cycle
);

    for (genvar f = 0; f < 4; f++) begin : g_lane
        assign eff_setup[f*8 +: 8] = expand_setup(setup_word[f*8 +: 6]);
        assign eff_pulse[f*9 +: 9] = expand_pulse(pulse_word[f*8 +: 7]);
    end

    for (genvar k = 0; k < 2; k++) begin : g_cyc
        assign eff_cycle[k*10 +: 10] = expand_cycle(cycle_word[k*16 +: 9]);
    end

endmodule

// File: rtl/tcfg_wp_guard.sv
module tcfg_wp_guard
    import tcfg_pkg::*;
#(
    parameter int NREG   = 16,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              prot_en,
    output logic              wr_ok,
    output logic              viol,
    output logic              flag_o,
    output logic [7:0]        src_o
);

    localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(NREG + 1);

    wp_st_t st_d, st_q;
    logic   is_cfg, rd_stat;

    always_comb begin
        is_cfg  = req_addr < ADDR_W'(NREG);
        viol    = req_valid && req_write && prot_en && is_cfg;
        wr_ok   = req_valid && req_write && !viol;
        rd_stat = req_valid && !req_write && (req_addr == IDX_STAT);
        st_d    = st_q;
        if (rd_stat) st_d.flag = 1'b0;
        if (viol) begin
            st_d.flag = 1'b1;
            st_d.src  = 8'(req_addr);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flag_o = st_q.flag;
    assign src_o  = st_q.src;

    AST_VIOL_SETS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> flag_o); // R5
    AST_FLAG_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_o && !rd_stat) |=> flag_o); // R5
    AST_SRC_RECORDED: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> (src_o == 8'($past(req_addr)))); // R6
    AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_stat && !viol) |=> !flag_o); // R7

endmodule

// File: rtl/tcfg_regfile.sv
module tcfg_regfile
    import tcfg_pkg::*;
#(
    parameter int NUM_CS = 4,
    parameter int ADDR_W = $clog2(4 * NUM_CS + 2)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   req_valid,
    input  logic                   req_write,
    input  logic [ADDR_W-1:0]      req_addr,
    input  logic [31:0]            req_wdata,
    output logic [31:0]            rd_data,
    output logic [NUM_CS*4*8-1:0]  eff_setup,
    output logic [NUM_CS*4*9-1:0]  eff_pulse,
    output logic [NUM_CS*2*10-1:0] eff_cycle
);

    localparam int NREG = 4 * NUM_CS;
    localparam logic [ADDR_W-1:0] IDX_PROT = ADDR_W'(NREG);
    localparam logic [ADDR_W-1:0] IDX_STAT = ADDR_W'(NREG + 1);

    typedef struct packed {
        logic [NREG-1:0][31:0] cfg;
        logic                  prot_en;
        logic [31:0]           rdata;
    } bank_st_t;

    bank_st_t   st_d, st_q;
    logic       wr_ok, viol, flag;
    logic [7:0] src;

    tcfg_wp_guard #(.NREG(NREG), .ADDR_W(ADDR_W)) i_guard (
        .clk      (clk),
        .rst_n    (rst_n),
        .req_valid(req_valid),
        .req_write(req_write),
        .req_addr (req_addr),
        .prot_en  (st_q.prot_en),
        .wr_ok    (wr_ok),
        .viol     (viol),
        .flag_o   (flag),
        .src_o    (src)
    );

    always_comb begin
        st_d = st_q;
        if (wr_ok) begin
            for (int i = 0; i < NREG; i++) begin
                if (req_addr == ADDR_W'(i))
                    st_d.cfg[i] = req_wdata & kind_mask(2'(i % 4));
            end
            if (req_addr == IDX_PROT) st_d.prot_en = req_wdata[0];
        end
        if (req_valid && !req_write) begin
            st_d.rdata = '0;
            for (int i = 0; i < NREG; i++) begin
                if (req_addr == ADDR_W'(i)) st_d.rdata = st_q.cfg[i];
            end
            if (req_addr == IDX_PROT) st_d.rdata = {31'b0, st_q.prot_en};
            if (req_addr == IDX_STAT) st_d.rdata = {16'b0, src, 7'b0, flag};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data = st_q.rdata;

    for (genvar c = 0; c < NUM_CS; c++) begin : g_cs
        tcfg_decode i_dec (
            .setup_word(st_q.cfg[4*c]),
            .pulse_word(st_q.cfg[4*c+1]),
            .cycle_word(st_q.cfg[4*c+2]),
            .eff_setup (eff_setup[c*32 +: 32]),
            .eff_pulse (eff_pulse[c*36 +: 36]),
            .eff_cycle (eff_cycle[c*20 +: 20])
        );
    end

    AST_BLOCKED_UNCHANGED: assert property (@(posedge clk) disable iff (!rst_n)
        viol |=> $stable(st_q.cfg)); // R4
    AST_GUARD_WRITABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == IDX_PROT)
        |=> (st_q.prot_en == $past(req_wdata[0]))); // R3
    AST_HIGH_WRITE_NOP: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr > IDX_PROT)
        |=> ($stable(st_q.cfg) && $stable(st_q.prot_en))); // R8

endmodule

// File: tb/test_tcfg_regfile.sv
`timescale 1ns/1ps
module test_tcfg_regfile;

    localparam int NUM_CS = 4;
    localparam int AW     = $clog2(4 * NUM_CS + 2);
    localparam int PROT   = 4 * NUM_CS;
    localparam int STAT   = 4 * NUM_CS + 1;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   req_valid = 1'b0;
    logic                   req_write = 1'b0;
    logic [AW-1:0]          req_addr = '0;
    logic [31:0]            req_wdata = '0;
    logic [31:0]            rd_data;
    logic [NUM_CS*4*8-1:0]  eff_setup;
    logic [NUM_CS*4*9-1:0]  eff_pulse;
    logic [NUM_CS*2*10-1:0] eff_cycle;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    tcfg_regfile #(.NUM_CS(NUM_CS)) i_tcfg_regfile (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata), .rd_data(rd_data),
        .eff_setup(eff_setup), .eff_pulse(eff_pulse), .eff_cycle(eff_cycle)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a); req_wdata = d;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        @(negedge clk);
        req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a);
        @(negedge clk);
        req_valid = 1'b0;
        d = rd_data;
    endtask

    function automatic int x_setup(input logic [5:0] c);
        return 128 * c[5] + c[4:0];
    endfunction
    function automatic int x_pulse(input logic [6:0] c);
        return 256 * c[6] + c[5:0];
    endfunction
    function automatic int x_cycle(input logic [8:0] c);
        return 256 * c[8:7] + c[6:0];
    endfunction

    task automatic t_reset();
        logic [31:0] v;
        chk("R1 eff_setup zero", 32'(eff_setup != 0), 32'd0);
        chk("R1 eff_pulse zero", 32'(eff_pulse != 0), 32'd0);
        chk("R1 eff_cycle zero", 32'(eff_cycle != 0), 32'd0);
        rd(5, v);    chk("R1 cs1 pulse word", v, 32'd0);
        rd(PROT, v); chk("R1 guard off", v, 32'd0);
        rd(STAT, v); chk("R1 status clear", v, 32'd0);
    endtask

    task automatic t_map();
        logic [31:0] v;
        wr(0, 32'hFFFF_FFFF); rd(0, v); chk("R2 setup mask", v, 32'h3F3F_3F3F);
        wr(1, 32'hFFFF_FFFF); rd(1, v); chk("R2 pulse mask", v, 32'h7F7F_7F7F);
        wr(2, 32'hFFFF_FFFF); rd(2, v); chk("R2 cycle mask", v, 32'h01FF_01FF);
        wr(3, 32'hFFFF_FFFF); rd(3, v); chk("R2 mode mask", v, 32'h0000_00FF);
        wr(13, 32'h0000_00A5); rd(13, v); chk("R2 cs3 pulse word", v, 32'h0000_0025);
        rd(9, v); chk("R2 cs2 pulse untouched", v, 32'd0);
    endtask

    task automatic t_decode();
        logic [5:0] sc [4] = '{6'h3F, 6'h20, 6'h1F, 6'h0A};
        logic [6:0] pc [4] = '{7'h7F, 7'h40, 7'h3F, 7'h45};
        logic [8:0] yc [2] = '{9'h1FF, 9'h0C3};
        wr(4, {2'b0, sc[3], 2'b0, sc[2], 2'b0, sc[1], 2'b0, sc[0]});
        wr(5, {1'b0, pc[3], 1'b0, pc[2], 1'b0, pc[1], 1'b0, pc[0]});
        wr(6, {7'b0, yc[1], 7'b0, yc[0]});
        for (int f = 0; f < 4; f++) begin
            chk($sformatf("R9 setup f%0d", f), 32'(eff_setup[(4+f)*8 +: 8]), 32'(x_setup(sc[f])));
            chk($sformatf("R10 pulse f%0d", f), 32'(eff_pulse[(4+f)*9 +: 9]), 32'(x_pulse(pc[f])));
        end
        chk("R11 cycle rd", 32'(eff_cycle[2*10 +: 10]), 32'(x_cycle(yc[0])));
        chk("R11 cycle wr", 32'(eff_cycle[3*10 +: 10]), 32'(x_cycle(yc[1])));
        wr(10, 32'h0180_007F);
        chk("R11 cycle rd 127", 32'(eff_cycle[4*10 +: 10]), 32'd127);
        chk("R11 cycle wr 768", 32'(eff_cycle[5*10 +: 10]), 32'd768);
    endtask

    task automatic t_protect();
        logic [31:0] v;
        wr(8, 32'h0000_0011);
        wr(PROT, 32'h1); rd(PROT, v); chk("R3 guard on", v, 32'h1);
        wr(8, 32'h0000_0022); rd(8, v); chk("R4 setup kept", v, 32'h0000_0011);
        wr(11, 32'h0000_0055); rd(11, v); chk("R4 mode kept", v, 32'h0);
        rd(STAT, v); chk("R6 index overwritten, R5 flag set", v, {16'b0, 8'd11, 8'h01});
        wr(15, 32'h1);
        rd(STAT, v); chk("R5 flag after refused write", v[0], 1'b1);
        chk("R6 src index 15", 32'(v[15:8]), 32'd15);
        wr(PROT, 32'h0); rd(PROT, v); chk("R3 guard writable while on", v, 32'h0);
        wr(8, 32'h0000_0033); rd(8, v); chk("R4 write allowed again", v, 32'h0000_0033);
    endtask

    task automatic t_status_clear();
        logic [31:0] v;
        wr(PROT, 32'h1);
        wr(2, 32'h1);
        wr(PROT, 32'h0);
        rd(STAT, v); chk("R7 first read shows flag", v, {16'b0, 8'd2, 8'h01});
        rd(STAT, v); chk("R7 flag cleared, index kept", v, {16'b0, 8'd2, 8'h00});
    endtask

    task automatic t_ignored();
        logic [31:0] v;
        wr(STAT, 32'hFFFF_FFFF); rd(STAT, v); chk("R8 status not writable", v, {16'b0, 8'd2, 8'h00});
        wr(STAT + 1, 32'hFFFF_FFFF);
        rd(PROT, v); chk("R8 high write no guard change", v, 32'h0);
        rd(8, v); chk("R8 high write no cfg change", v, 32'h0000_0033);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_decode();
        t_protect();
        t_status_clear();
        t_ignored();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_cmp++; n_bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule